// File: doc/BRIEF.md
# Byte-Block Character Class Unit

The block accepts a wide block of bytes in one cycle. It splits the block into eight bit planes. Plane `i` gathers bit `i` of every byte, with byte position `j` placed at bit `j` of the plane. From these planes it builds several character-class vectors. Bit `j` of a class vector tells whether byte `j` falls inside that class. All of this uses only AND, OR and NOT across whole planes, so every byte position is classified in parallel. No per-byte comparator stream is formed.

Each class slot holds a lower bound, an upper bound and an invert flag. A small write port loads these values. A single character is written with both bounds equal. Both bounds at the extremes select every code. A lower bound above the upper bound selects nothing. The invert flag turns any of these into its complement.

The input side and the output side each use a valid/ready handshake. The result is registered: it appears one cycle after a block is accepted, and a new block can be taken on every cycle while the consumer keeps up.

Top module: `ccu_class_unit`

## Requirements
- R1: After a block is accepted, `out_basis[i*BLOCK_BYTES + j]` equals bit `i` of byte `j`, where byte `j` is `in_bytes[j*8 +: 8]`.
- R2: With the invert flag clear, bit `j` of class `k` (`out_class[k*BLOCK_BYTES + j]`) is 1 exactly when `lo_k <= byte_j <= hi_k`. Both bounds are inclusive, and equal bounds select one character.
- R3: With the invert flag set, bit `j` of class `k` is the complement of the R2 result for the same bounds.
- R4: Bounds `lo=0x00, hi=0xFF` with the invert flag clear set every bit of the class vector. A lower bound above the upper bound with the invert flag clear clears every bit.
- R5: After reset, `out_valid` is 0. Every slot holds an empty class (`lo=0x01, hi=0x00`, invert clear), so blocks give all-zero class vectors until the slot is written.
- R6: A block accepted on a rising edge (`in_valid && in_ready`) appears on the outputs with `out_valid=1` right after that edge. Blocks can be accepted back to back. With no block accepted and `out_ready=1`, `out_valid` falls.
- R7: While `out_valid=1` and `out_ready=0`, `in_ready` is 0 and `out_basis`/`out_class` hold their values.
- R8: A write (`cfg_we=1`) to slot `cfg_slot` takes effect for blocks accepted on later edges. A block accepted on the same edge as the write uses the previous setting. Other slots are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_slot | input | SLOT_W | Slot index written |
| cfg_lo | input | 8 | Lower bound, inclusive |
| cfg_hi | input | 8 | Upper bound, inclusive |
| cfg_neg | input | 1 | Invert the class |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Block can be taken this cycle |
| in_bytes | input | 8*BLOCK_BYTES | Byte `j` at bits `[j*8 +: 8]` |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_basis | output | 8*BLOCK_BYTES | Plane `i` at `[i*BLOCK_BYTES +: BLOCK_BYTES]` |
| out_class | output | NUM_CLASSES*BLOCK_BYTES | Class `k` at `[k*BLOCK_BYTES +: BLOCK_BYTES]` |

## Verification
The bench builds the unit with `BLOCK_BYTES=16` and the default four slots. Sixteen back-to-back blocks then cover all 256 byte codes. Every configuration is checked against the full code space, including both range ends, the single-character case, the empty case and the full range, with and without inversion. The small block also keeps the stall and same-edge write cases short enough to step through one cycle at a time.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
   localparam int BYTE_W = 8;

   typedef struct packed {
      logic [BYTE_W-1:0] lo;
      logic [BYTE_W-1:0] hi;
      logic              neg;
   } cls_cfg_t;

   localparam cls_cfg_t CFG_EMPTY = '{lo: 8'h01, hi: 8'h00, neg: 1'b0};
endpackage

// File: rtl/ccu_transpose.sv
module ccu_transpose #(
   parameter int W = 128
) (
   input  logic [W*ccu_pkg::BYTE_W-1:0] bytes_i,
   output logic [ccu_pkg::BYTE_W*W-1:0] planes_o
);
   localparam int BW = ccu_pkg::BYTE_W;

   for (genvar p = 0; p < BW; p++) begin : g_plane
      for (genvar j = 0; j < W; j++) begin : g_pos
         assign planes_o[p*W + j] = bytes_i[j*BW + p];
      end
   end
endmodule

// File: rtl/ccu_cfg_bank.sv
module ccu_cfg_bank #(
   parameter int N      = 4,
   parameter int SLOT_W = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we_i,
   input  logic [SLOT_W-1:0]             slot_i,
   input  ccu_pkg::cls_cfg_t             data_i,
   output ccu_pkg::cls_cfg_t [N-1:0]     cfg_o
);
   for (genvar k = 0; k < N; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            cfg_o[k] <= ccu_pkg::CFG_EMPTY;
         else if (we_i && (int'(slot_i) == k))
            cfg_o[k] <= data_i;
      end
   end
endmodule

// File: rtl/ccu_range_class.sv
module ccu_range_class #(
   parameter int W = 128
) (
   input  logic [ccu_pkg::BYTE_W*W-1:0] planes_i,
   input  ccu_pkg::cls_cfg_t            cfg_i,
   output logic [W-1:0]                 class_o
);
   localparam int BW = ccu_pkg::BYTE_W;

   logic [W-1:0] gt_lo, eq_lo, lt_hi, eq_hi, plane, m_lo, m_hi;

   // Magnitude compare against both bounds, most significant plane first,
   // using only whole-vector AND/OR/NOT with the bound bits replicated.
   always_comb begin
      gt_lo = '0;
      eq_lo = '1;
      lt_hi = '0;
      eq_hi = '1;
      plane = '0;
      m_lo  = '0;
      m_hi  = '0;
      for (int p = BW-1; p >= 0; p--) begin
         plane = planes_i[p*W +: W];
         m_lo  = {W{cfg_i.lo[p]}};
         m_hi  = {W{cfg_i.hi[p]}};
         gt_lo = gt_lo | (eq_lo & plane & ~m_lo);
         eq_lo = eq_lo & ~(plane ^ m_lo);
         lt_hi = lt_hi | (eq_hi & ~plane & m_hi);
         eq_hi = eq_hi & ~(plane ^ m_hi);
      end
      class_o = ((gt_lo | eq_lo) & (lt_hi | eq_hi)) ^ {W{cfg_i.neg}};
   end
endmodule

// File: rtl/ccu_class_unit.sv
module ccu_class_unit #(
   parameter int BLOCK_BYTES = 128,
   parameter int NUM_CLASSES = 4,
   localparam int SLOT_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic [SLOT_W-1:0]                 cfg_slot,
   input  logic [7:0]                        cfg_lo,
   input  logic [7:0]                        cfg_hi,
   input  logic                              cfg_neg,
   input  logic                              in_valid,
   output logic                              in_ready,
   input  logic [8*BLOCK_BYTES-1:0]          in_bytes,
   output logic                              out_valid,
   input  logic                              out_ready,
   output logic [8*BLOCK_BYTES-1:0]          out_basis,
   output logic [NUM_CLASSES*BLOCK_BYTES-1:0] out_class
);
   import ccu_pkg::*;

   localparam int PLANE_BITS = BYTE_W * BLOCK_BYTES;
   localparam int CLASS_BITS = NUM_CLASSES * BLOCK_BYTES;

   if (BLOCK_BYTES < 1) begin : g_bad_block
      $error("BLOCK_BYTES must be at least 1");
   end
   if (NUM_CLASSES < 1) begin : g_bad_classes
      $error("NUM_CLASSES must be at least 1");
   end

   cls_cfg_t [NUM_CLASSES-1:0] cfg_q;
   cls_cfg_t                   cfg_wr;
   logic [PLANE_BITS-1:0]      planes;
   logic [CLASS_BITS-1:0]      class_d;
   logic                       take;

   assign cfg_wr = '{lo: cfg_lo, hi: cfg_hi, neg: cfg_neg};

   ccu_cfg_bank #(.N(NUM_CLASSES), .SLOT_W(SLOT_W)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (cfg_we),
      .slot_i (cfg_slot),
      .data_i (cfg_wr),
      .cfg_o  (cfg_q)
   );

   ccu_transpose #(.W(BLOCK_BYTES)) u_tp (
      .bytes_i  (in_bytes),
      .planes_o (planes)
   );

   for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_cls
      ccu_range_class #(.W(BLOCK_BYTES)) u_rc (
         .planes_i (planes),
         .cfg_i    (cfg_q[k]),
         .class_o  (class_d[k*BLOCK_BYTES +: BLOCK_BYTES])
      );
   end

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_basis <= '0;
         out_class <= '0;
      end else if (take) begin
         out_valid <= 1'b1;
         out_basis <= planes;
         out_class <= class_d;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/ccu_class_unit_chk.sv
module ccu_class_unit_chk #(
   parameter int W = 128,
   parameter int N = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_ready,
   input logic [8*W-1:0]     in_bytes,
   input logic               out_valid,
   input logic               out_ready,
   input logic [8*W-1:0]     out_basis,
   input logic [N*W-1:0]     out_class
);
   p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!(in_valid && in_ready) && out_ready) |=> !out_valid);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_basis) && $stable(out_class)));

   p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   for (genvar p = 0; p < 8; p++) begin : g_b
      p_plane_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_ready) |=> (out_basis[p*W] == $past(in_bytes[p])));
   end
endmodule

bind ccu_class_unit ccu_class_unit_chk #(.W(BLOCK_BYTES), .N(NUM_CLASSES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_bytes  (in_bytes),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_basis (out_basis),
   .out_class (out_class)
);

// File: tb/ccu_class_unit_bench.sv
module ccu_class_unit_bench;
   localparam int W = 16;
   localparam int N = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [1:0]       cfg_slot = '0;
   logic [7:0]       cfg_lo = '0, cfg_hi = '0;
   logic             cfg_neg = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [8*W-1:0]   in_bytes = '0;
   logic             out_valid;
   logic             out_ready = 1'b1;
   logic [8*W-1:0]   out_basis;
   logic [N*W-1:0]   out_class;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [7:0] m_lo [N];
   logic [7:0] m_hi [N];
   logic       m_neg[N];

   always #4 clk = ~clk;

   ccu_class_unit #(.BLOCK_BYTES(W), .NUM_CLASSES(N)) u_ccu_class_unit (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
      .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_neg(cfg_neg),
      .in_valid(in_valid), .in_ready(in_ready), .in_bytes(in_bytes),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_basis(out_basis), .out_class(out_class)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [8*W-1:0] mk_block(input int base);
      logic [8*W-1:0] b;
      for (int j = 0; j < W; j++) b[j*8 +: 8] = 8'((base + j) & 255);
      return b;
   endfunction

   // Check outputs against a block whose byte j is (base + j) mod 256.
   task automatic check_out(input int base, input string req);
      logic [8*W-1:0] eb;
      logic [W-1:0]   ec;
      logic [7:0]     v;
      for (int p = 0; p < 8; p++)
         for (int j = 0; j < W; j++) begin
            v = 8'((base + j) & 255);
            eb[p*W + j] = v[p];
         end
      chk({req, " valid"}, 128'(out_valid), 128'(1));
      chk({"R1 planes ", req}, 128'(out_basis), 128'(eb));
      for (int k = 0; k < N; k++) begin
         for (int j = 0; j < W; j++) begin
            v = 8'((base + j) & 255);
            ec[j] = m_neg[k] ^ ((v >= m_lo[k]) && (v <= m_hi[k]));
         end
         chk({"R2 R3 R4 class ", req}, 128'(out_class[k*W +: W]), 128'(ec));
      end
   endtask

   task automatic write_cfg(input int k, input logic [7:0] lo, input logic [7:0] hi, input logic ng);
      @(negedge clk);
      cfg_we = 1'b1; cfg_slot = 2'(k); cfg_lo = lo; cfg_hi = hi; cfg_neg = ng;
      @(negedge clk);
      cfg_we = 1'b0;
      m_lo[k] = lo; m_hi[k] = hi; m_neg[k] = ng;
   endtask

   // Stream all 256 codes back to back, checking each block one cycle later.
   task automatic sweep(input string req);
      for (int blk = 0; blk <= 16; blk++) begin
         @(negedge clk);
         if (blk > 0) check_out((blk-1)*W, req);
         if (blk < 16) begin
            in_valid = 1'b1;
            in_bytes = mk_block(blk*W);
         end else in_valid = 1'b0;
      end
      @(negedge clk);
      chk("R6 drain", 128'(out_valid), 128'(0));
   endtask

   initial begin
      for (int k = 0; k < N; k++) begin
         m_lo[k] = 8'h01; m_hi[k] = 8'h00; m_neg[k] = 1'b0;
      end
      repeat (3) @(negedge clk);
      chk("R5 reset valid", 128'(out_valid), 128'(0));
      chk("R5 reset ready", 128'(in_ready), 128'(1));
      rst_n = 1'b1;
      sweep("R5 empty slots");

      write_cfg(0, 8'h30, 8'h39, 1'b0);
      write_cfg(1, 8'h61, 8'h61, 1'b0);
      write_cfg(2, 8'h00, 8'hFF, 1'b0);
      write_cfg(3, 8'h41, 8'h5A, 1'b1);
      sweep("R2 set A");

      write_cfg(0, 8'h80, 8'hFF, 1'b0);
      write_cfg(1, 8'h10, 8'h0F, 1'b1);
      write_cfg(2, 8'hFF, 8'hFF, 1'b0);
      write_cfg(3, 8'h00, 8'h00, 1'b1);
      sweep("R4 set B");

      for (int r = 0; r < 6; r++) begin
         for (int k = 0; k < N; k++)
            write_cfg(k, 8'((r*37 + k*19) & 255), 8'((r*53 + k*71 + 40) & 255),
                      1'((r + k) & 1));
         sweep("R3 arith set");
      end

      // R7: stall holds the result and blocks new input
      @(negedge clk);
      out_ready = 1'b0; in_valid = 1'b1; in_bytes = mk_block(16);
      @(negedge clk);
      in_bytes = mk_block(160);
      check_out(16, "R7 stall first");
      chk("R7 in_ready low", 128'(in_ready), 128'(0));
      @(negedge clk);
      check_out(16, "R7 stall hold");
      out_ready = 1'b1;
      @(negedge clk);
      check_out(160, "R6 release");
      in_valid = 1'b0;
      @(negedge clk);
      chk("R6 idle drop", 128'(out_valid), 128'(0));

      // R8: write on the same edge as a block; that block uses the old slot
      @(negedge clk);
      cfg_we = 1'b1; cfg_slot = 2'd2; cfg_lo = 8'h20; cfg_hi = 8'h27; cfg_neg = 1'b0;
      in_valid = 1'b1; in_bytes = mk_block(32);
      @(negedge clk);
      cfg_we = 1'b0;
      in_bytes = mk_block(32);
      check_out(32, "R8 old setting");
      m_lo[2] = 8'h20; m_hi[2] = 8'h27; m_neg[2] = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      check_out(32, "R8 new setting");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule